// File: doc/BRIEF.md
# Type 1 Bridge Header Shim for a Type 0 Root Port

This block sits between a configuration access master and a root port whose configuration space is laid out as a Type 0 header. It makes that root port look like a compliant Type 1 bridge. Accesses to the bridge-specific dwords are answered from a small local shadow register file and never reach the real registers, because the real registers at those offsets control unrelated internal address translation. All other offsets pass through unchanged.

On the read path the block rewrites two fields that the hardware reports incorrectly: the header type is forced to Type 1 and the class code to PCI-to-PCI bridge. On the write path it watches the bus-number dword in the shadow. When the secondary bus byte is written, the block updates a local bus number output, which downstream routing uses to decide the type of config request.

The upstream port takes one request per cycle with a dword index, byte enables and write data. At most one pass-through read may be outstanding at a time. Reads are answered by a one-cycle response pulse. Writes produce no response.

Top module: `cfg_bridge_shim`

## Requirements
- R1: Requests to dword indices 4 to 12 (offsets 0x10 to 0x33) and 14 (offset 0x38) are served by the shadow. `dn_valid_o` stays low for them, and a shadow write is read back on a later read of the same index.
- R2: Requests to any other index drive `dn_valid_o` in the same cycle, with `dn_write_o`, `dn_addr_o`, `dn_be_o` and `dn_wdata_o` equal to the request fields.
- R3: Writes to index 4 (BAR0), 5 (BAR1) and 14 (expansion ROM) store zero whatever the data or byte enables. Other shadow dwords, including index 12, keep the written data.
- R4: A shadow write updates only the bytes whose `req_be_i` bit is set (bit n covers data bits 8n+7:8n). The other bytes keep their previous value.
- R5: A read of index 3 returns the real data with bits 22:16 replaced by 0x01. All other bits are unchanged.
- R6: A read of index 2 returns the real data with bits 31:8 replaced by 0x060400. Bits 7:0 are unchanged.
- R7: A write to index 6 with `req_be_i[1]` set loads `local_bus_o` from `req_wdata_i[15:8]`, visible the cycle after the request. Any other request leaves `local_bus_o` unchanged.
- R8: A write to index 6 with `req_be_i[0]` set stores the primary bus number in byte 0 of that shadow dword, and it reads back without changing `local_bus_o`.
- R9: After reset, index 7 reads 0x00000101 and index 9 reads 0x00010001. Every other shadow dword reads 0, and `local_bus_o` is 0.
- R10: A shadow read raises `rsp_valid_o` in the cycle after the request. A pass-through read raises `rsp_valid_o` in the cycle after `dn_rvalid_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Upstream request strobe |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Dword index into config space |
| req_be_i | input | 4 | Byte enables |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Read response strobe |
| rsp_rdata_o | output | 32 | Read response data |
| dn_valid_o | output | 1 | Pass-through request strobe |
| dn_write_o | output | 1 | Pass-through write flag |
| dn_addr_o | output | ADDR_W | Pass-through dword index |
| dn_be_o | output | 4 | Pass-through byte enables |
| dn_wdata_o | output | 32 | Pass-through write data |
| dn_rvalid_i | input | 1 | Real config space read data valid |
| dn_rdata_i | input | 32 | Real config space read data |
| local_bus_o | output | 8 | Local bus number from secondary bus writes |

## Verification
The bench targets the edges of the shadow window. Index 13 sits inside the window but must pass through, and index 12 must be stored while its neighbour 14 is forced to zero. A decoder off by one would leak a write into the real registers or drop a capability pointer read. Partial byte-enable writes cover both the merge and its interaction with the forced-zero BARs: a merge applied after zeroing would leave stale bytes in BAR0. The bus-number dword is written with byte 0 alone, byte 1 alone and all bytes. This exposes a design that takes the local bus from the primary byte, or that updates it on a write without the secondary byte enabled. The header type and class code reads use real data with the multi-function bit and revision set, which catches a mask that is too wide.

// File: rtl/cfg_shim_pkg.sv
package cfg_shim_pkg;
  localparam int unsigned DATA_W      = 32;
  localparam int unsigned BE_W        = DATA_W / 8;
  localparam int unsigned NUM_SHADOW  = 11;
  localparam int unsigned SLOT_W      = $clog2(NUM_SHADOW);
  localparam int unsigned SHADOW_BASE = 4;   // dword index of offset 0x10
  localparam int unsigned SHADOW_LAST = 12;  // dword index of offset 0x30
  localparam int unsigned IDX_CLASS   = 2;
  localparam int unsigned IDX_HDR     = 3;
  localparam int unsigned IDX_BAR0    = 4;
  localparam int unsigned IDX_BAR1    = 5;
  localparam int unsigned IDX_BUS     = 6;
  localparam int unsigned IDX_IOWIN   = 7;
  localparam int unsigned IDX_PFWIN   = 9;
  localparam int unsigned IDX_ROM     = 14;

  localparam logic [23:0] BRIDGE_CLASS = 24'h060400;
  localparam logic [6:0]  HDR_TYPE1    = 7'h01;

  typedef enum logic [1:0] {
    PATCH_NONE  = 2'd0,
    PATCH_CLASS = 2'd1,
    PATCH_HDR   = 2'd2
  } patch_e;

  function automatic logic [DATA_W-1:0] merge_bytes(
    input logic [DATA_W-1:0] old_d,
    input logic [DATA_W-1:0] new_d,
    input logic [BE_W-1:0]   be
  );
    logic [DATA_W-1:0] r;
    for (int b = 0; b < BE_W; b++)
      r[b*8 +: 8] = be[b] ? new_d[b*8 +: 8] : old_d[b*8 +: 8];
    return r;
  endfunction

  // Reset image of a shadow slot (slot = dword index - SHADOW_BASE)
  function automatic logic [DATA_W-1:0] slot_reset(input int unsigned slot);
    if (slot == IDX_IOWIN - SHADOW_BASE) return 32'h0000_0101;
    if (slot == IDX_PFWIN - SHADOW_BASE) return 32'h0001_0001;
    return '0;
  endfunction
endpackage

// File: rtl/cfg_shim_decode.sv
module cfg_shim_decode
  import cfg_shim_pkg::*;
#(
  parameter int unsigned ADDR_W = 10
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              zero_o,
  output logic              bus_o,
  output patch_e            patch_o
);
  logic [ADDR_W-1:0] off;
  logic              in_block;

  assign off      = addr_i - ADDR_W'(SHADOW_BASE);
  assign in_block = (addr_i >= ADDR_W'(SHADOW_BASE)) && (addr_i <= ADDR_W'(SHADOW_LAST));
  assign hit_o    = in_block || (addr_i == ADDR_W'(IDX_ROM));
  assign slot_o   = off[SLOT_W-1:0];
  assign zero_o   = (addr_i == ADDR_W'(IDX_BAR0)) || (addr_i == ADDR_W'(IDX_BAR1)) ||
                    (addr_i == ADDR_W'(IDX_ROM));
  assign bus_o    = (addr_i == ADDR_W'(IDX_BUS));

  always_comb begin
    patch_o = PATCH_NONE;
    if (addr_i == ADDR_W'(IDX_CLASS))    patch_o = PATCH_CLASS;
    else if (addr_i == ADDR_W'(IDX_HDR)) patch_o = PATCH_HDR;
  end
endmodule

// File: rtl/cfg_shim_shadow.sv
module cfg_shim_shadow
  import cfg_shim_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [BE_W-1:0]   be_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              zero_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] regs_w [NUM_SHADOW];

  for (genvar g = 0; g < NUM_SHADOW; g++) begin : g_slot
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        q <= slot_reset(g);
      end else if (we_i && (slot_i == SLOT_W'(g))) begin
        // merge first, then the forced-zero rule wins
        q <= zero_i ? '0 : merge_bytes(q, wdata_i, be_i);
      end
    end
    assign regs_w[g] = q;
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_SHADOW; i++)
      if (slot_i == SLOT_W'(i)) rdata_o = regs_w[i];
  end
endmodule

// File: rtl/cfg_shim_patch.sv
module cfg_shim_patch
  import cfg_shim_pkg::*;
(
  input  patch_e            kind_i,
  input  logic [DATA_W-1:0] raw_i,
  output logic [DATA_W-1:0] fix_o
);
  always_comb begin
    fix_o = raw_i;
    unique case (kind_i)
      PATCH_CLASS: fix_o[31:8]  = BRIDGE_CLASS;
      PATCH_HDR:   fix_o[22:16] = HDR_TYPE1;
      default:     fix_o = raw_i;
    endcase
  end
endmodule

// File: rtl/cfg_bridge_shim.sv
module cfg_bridge_shim
  import cfg_shim_pkg::*;
#(
  parameter int unsigned ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [3:0]        req_be_i,
  input  logic [31:0]       req_wdata_i,
  output logic              rsp_valid_o,
  output logic [31:0]       rsp_rdata_o,
  output logic              dn_valid_o,
  output logic              dn_write_o,
  output logic [ADDR_W-1:0] dn_addr_o,
  output logic [3:0]        dn_be_o,
  output logic [31:0]       dn_wdata_o,
  input  logic              dn_rvalid_i,
  input  logic [31:0]       dn_rdata_i,
  output logic [7:0]        local_bus_o
);
  logic              hit, zero, bus_dw;
  logic [SLOT_W-1:0] slot;
  patch_e            patch_kind, pend_kind_q;
  logic [DATA_W-1:0] sh_rdata, fixed_data;
  logic              sh_we, sh_rd, dn_rd;
  logic              rsp_valid_q;
  logic [DATA_W-1:0] rsp_data_q;
  logic [7:0]        local_bus_q;

  cfg_shim_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i (req_addr_i),
    .hit_o  (hit),
    .slot_o (slot),
    .zero_o (zero),
    .bus_o  (bus_dw),
    .patch_o(patch_kind)
  );

  assign sh_we = req_valid_i &  req_write_i & hit;
  assign sh_rd = req_valid_i & ~req_write_i & hit;
  assign dn_rd = req_valid_i & ~req_write_i & ~hit;

  cfg_shim_shadow u_shadow (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (sh_we),
    .slot_i (slot),
    .be_i   (req_be_i),
    .wdata_i(req_wdata_i),
    .zero_i (zero),
    .rdata_o(sh_rdata)
  );

  cfg_shim_patch u_patch (
    .kind_i(pend_kind_q),
    .raw_i (dn_rdata_i),
    .fix_o (fixed_data)
  );

  assign dn_valid_o = req_valid_i & ~hit;
  assign dn_write_o = req_write_i;
  assign dn_addr_o  = req_addr_i;
  assign dn_be_o    = req_be_i;
  assign dn_wdata_o = req_wdata_i;

  // one pass-through read outstanding: remember which patch its data needs
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pend_kind_q <= PATCH_NONE;
    else if (dn_rd) pend_kind_q <= patch_kind;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      rsp_valid_q <= sh_rd | dn_rvalid_i;
      if (dn_rvalid_i) rsp_data_q <= fixed_data;
      else if (sh_rd)  rsp_data_q <= sh_rdata;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          local_bus_q <= '0;
    else if (sh_we && bus_dw && req_be_i[1]) local_bus_q <= req_wdata_i[15:8];
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_rdata_o = rsp_data_q;
  assign local_bus_o = local_bus_q;
endmodule

// File: rtl/cfg_shim_checker.sv
module cfg_shim_checker #(
  parameter int unsigned ADDR_W = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_write_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic [3:0]        req_be_i,
  input logic [31:0]       req_wdata_i,
  input logic              rsp_valid_o,
  input logic              dn_valid_o,
  input logic [ADDR_W-1:0] dn_addr_o,
  input logic              dn_rvalid_i,
  input logic [7:0]        local_bus_o
);
  logic in_win, bus_wr;
  assign in_win = (req_addr_i >= ADDR_W'(4) && req_addr_i <= ADDR_W'(12)) ||
                  (req_addr_i == ADDR_W'(14));
  assign bus_wr = req_valid_i && req_write_i && (req_addr_i == ADDR_W'(6)) && req_be_i[1];

  assert_shadow_local_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && in_win) |-> !dn_valid_o);

  assert_passthru_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !in_win) |-> (dn_valid_o && dn_addr_o == req_addr_i));

  assert_bus_load_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_wr |=> (local_bus_o == $past(req_wdata_i[15:8])));

  assert_bus_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_wr |=> $stable(local_bus_o));

  assert_shadow_rsp_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_write_i && in_win) |=> rsp_valid_o);

  assert_dn_rsp_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_rvalid_i |=> rsp_valid_o);
endmodule

bind cfg_bridge_shim cfg_shim_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .req_write_i(req_write_i),
  .req_addr_i (req_addr_i),
  .req_be_i   (req_be_i),
  .req_wdata_i(req_wdata_i),
  .rsp_valid_o(rsp_valid_o),
  .dn_valid_o (dn_valid_o),
  .dn_addr_o  (dn_addr_o),
  .dn_rvalid_i(dn_rvalid_i),
  .local_bus_o(local_bus_o)
);

// File: tb/sim_cfg_bridge_shim.sv
`timescale 1ns/1ps
module sim_cfg_bridge_shim;
  localparam int AW = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [3:0]    req_be = '0;
  logic [31:0]   req_wdata = '0;
  logic          rsp_valid;
  logic [31:0]   rsp_rdata;
  logic          dn_valid, dn_write;
  logic [AW-1:0] dn_addr;
  logic [3:0]    dn_be;
  logic [31:0]   dn_wdata;
  logic          dn_rvalid = 1'b0;
  logic [31:0]   dn_rdata = '0;
  logic [7:0]    local_bus;

  int checks = 0, fails = 0, leaks = 0;
  logic [31:0] mem [64];

  always #2.5 clk = ~clk;

  cfg_bridge_shim #(.ADDR_W(AW)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_addr_i(req_addr),
    .req_be_i(req_be), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .dn_valid_o(dn_valid), .dn_write_o(dn_write), .dn_addr_o(dn_addr),
    .dn_be_o(dn_be), .dn_wdata_o(dn_wdata),
    .dn_rvalid_i(dn_rvalid), .dn_rdata_i(dn_rdata),
    .local_bus_o(local_bus)
  );

  // real config space model: one-cycle read latency
  always @(posedge clk) begin
    dn_rvalid <= 1'b0;
    if (dn_valid) begin
      if ((dn_addr >= 4 && dn_addr <= 12) || dn_addr == 14) leaks <= leaks + 1;
      if (dn_write) begin
        for (int b = 0; b < 4; b++)
          if (dn_be[b]) mem[dn_addr[5:0]][b*8 +: 8] <= dn_wdata[b*8 +: 8];
      end else begin
        dn_rvalid <= 1'b1;
        dn_rdata  <= mem[dn_addr[5:0]];
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_be = be; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic do_read(input logic [AW-1:0] a, output logic [31:0] d, output int lat);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_be = 4'hf;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0;
    while (!rsp_valid && lat < 8) begin
      @(negedge clk);
      lat++;
    end
    d = rsp_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] d; int lat;
    check(local_bus == 8'h00, "R9 local bus reset", {24'h0, local_bus}, 32'h0);
    do_read(7, d, lat);  check(d == 32'h0000_0101, "R9 io window reset", d, 32'h0000_0101);
    do_read(9, d, lat);  check(d == 32'h0001_0001, "R9 pref window reset", d, 32'h0001_0001);
    do_read(4, d, lat);  check(d == 32'h0, "R9 bar0 reset", d, 32'h0);
    do_read(6, d, lat);  check(d == 32'h0, "R9 bus dword reset", d, 32'h0);
  endtask

  task automatic t_shadow_local;
    logic [31:0] d; int lat;
    mem[8] = 32'h5555_5555;
    do_write(8, 4'hf, 32'hdead_beef);
    do_read(8, d, lat);
    check(d == 32'hdead_beef, "R1 shadow readback", d, 32'hdead_beef);
    check(lat == 0, "R10 shadow latency", lat, 0);
    check(mem[8] == 32'h5555_5555, "R1 real reg untouched", mem[8], 32'h5555_5555);
    do_write(12, 4'hf, 32'hffff_ffff);
    do_read(12, d, lat);
    check(d == 32'hffff_ffff, "R3 index 12 not zeroed", d, 32'hffff_ffff);
    check(leaks == 0, "R1 no downstream leak", leaks, 0);
  endtask

  task automatic t_passthru;
    logic [31:0] d; int lat;
    mem[0] = 32'h1234_abcd; mem[13] = 32'h0000_0040;
    do_read(0, d, lat);
    check(d == 32'h1234_abcd, "R2 id read", d, 32'h1234_abcd);
    check(lat == 1, "R10 passthru latency", lat, 1);
    do_read(13, d, lat);
    check(d == 32'h0000_0040, "R2 cap ptr read", d, 32'h40);
    mem[16] = 32'h0;
    do_write(16, 4'b0110, 32'haabb_ccdd);
    @(negedge clk);
    check(mem[16] == 32'h00bb_cc00, "R2 passthru write", mem[16], 32'h00bb_cc00);
  endtask

  task automatic t_zero;
    logic [31:0] d; int lat;
    do_write(4, 4'hf, 32'hffff_ffff); do_read(4, d, lat);
    check(d == 32'h0, "R3 bar0 zero", d, 0);
    do_write(5, 4'hf, 32'h8000_000c); do_read(5, d, lat);
    check(d == 32'h0, "R3 bar1 zero", d, 0);
    do_write(14, 4'b0001, 32'h0000_0001); do_read(14, d, lat);
    check(d == 32'h0, "R3 rom zero", d, 0);
  endtask

  task automatic t_merge;
    logic [31:0] d; int lat;
    do_write(10, 4'hf, 32'h1122_3344);
    do_write(10, 4'b0101, 32'haabb_ccdd);
    do_read(10, d, lat);
    check(d == 32'h11bb_33dd, "R4 byte merge", d, 32'h11bb_33dd);
    do_write(4, 4'b1000, 32'hff00_0000); do_read(4, d, lat);
    check(d == 32'h0, "R4 partial bar0 still zero", d, 0);
  endtask

  task automatic t_patch;
    logic [31:0] d; int lat;
    mem[3] = 32'h0080_0010;
    do_read(3, d, lat);
    check(d == 32'h0081_0010, "R5 header type", d, 32'h0081_0010);
    mem[2] = 32'h5080_0003;
    do_read(2, d, lat);
    check(d == 32'h0604_0003, "R6 class code", d, 32'h0604_0003);
  endtask

  task automatic t_bus;
    logic [31:0] d; int lat;
    do_write(6, 4'b0010, 32'h0000_2a00);
    check(local_bus == 8'h2a, "R7 secondary byte load", {24'h0, local_bus}, 32'h2a);
    do_write(6, 4'b0001, 32'h0000_ff05);
    check(local_bus == 8'h2a, "R7 primary-only write holds bus", {24'h0, local_bus}, 32'h2a);
    do_read(6, d, lat);
    check(d == 32'h0000_2a05, "R8 primary stored", d, 32'h0000_2a05);
    do_write(7, 4'b0010, 32'h0000_9900);
    check(local_bus == 8'h2a, "R7 other dword holds bus", {24'h0, local_bus}, 32'h2a);
    do_write(6, 4'hf, 32'h00ff_0703);
    check(local_bus == 8'h07, "R7 full write load", {24'h0, local_bus}, 32'h07);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_shadow_local();
    t_passthru();
    t_zero();
    t_merge();
    t_patch();
    t_bus();
    check(leaks == 0, "R1 no leak overall", leaks, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule